// File: doc/BRIEF.md
# Carry-Bit AND Boolean Unit

This block carries out the two bit-level AND operations of a small 8-bit controller's Boolean processor. A sequencer presents an opcode and an 8-bit bit address with a one-clock `start` pulse. The unit turns the bit address into a byte location and bit position, either in the bit-addressable internal RAM window or among the special registers. It reads that byte through a combinational read port, picks out the bit, optionally inverts it, and ANDs the result into the carry flag.

The carry is bit 7 of the status word. The unit takes the status word in and returns an updated copy with a one-clock write strobe. Each operation spans two instruction-cycle enables (`cyc_en`). The source bit is sampled on the first enable, and the carry is resolved on the second. For the four port bytes, the bit comes from the port output-latch model rather than from the special-register read path. The unit never writes memory, so the inverted form leaves the stored bit untouched. The carry can only be cleared or kept, never set.

Top module: `carry_and_unit`

## Requirements
- R1: After reset, `busy`, `done` and `status_we` are 0.
- R2: Opcode 0x82 gives new carry = old carry AND source bit.
- R3: Opcode 0xB0 gives new carry = old carry AND NOT source bit.
- R4: While busy with a bit address below 0x80, `rd_sfr` is 0, `rd_addr` is 0x20 + (address >> 3), and the bit taken is address[2:0].
- R5: While busy with a bit address of 0x80 or above, `rd_sfr` is 1, `rd_addr` is address AND 0xF8, and the bit taken is address[2:0].
- R6: For byte addresses 0x80, 0x90, 0xA0 and 0xB0, the byte comes from `port_latch[8*k +: 8]`, with k = address[5:4]. `sfr_rdata` is ignored for these bytes.
- R7: `done` and `status_we` are high for exactly one clock. That clock follows the edge at which the second `cyc_en` of the operation is seen while busy. `busy` is low in that clock.
- R8: With `done`, `status_out[6:0]` equals `status_in[6:0]` and bit 7 holds the new carry. The carry is never set by the unit.
- R9: A `start` with any opcode other than 0x82 or 0xB0 is ignored: `busy` stays low and no `done` follows.
- R10: A `start` while busy is ignored. The running operation keeps its address and inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | Instruction-cycle enable |
| start | input | 1 | Begin an operation (accepted only when idle) |
| opcode | input | 8 | Operation code presented with `start` |
| bit_addr | input | 8 | Direct bit address presented with `start` |
| rd_addr | output | 8 | Byte address of the source byte |
| rd_sfr | output | 1 | 1: special-register space, 0: internal RAM |
| ram_rdata | input | 8 | RAM byte at `rd_addr` |
| sfr_rdata | input | 8 | Special-register byte at `rd_addr` |
| port_latch | input | 32 | Four port output latches, port k at bits 8k+7..8k |
| status_in | input | 8 | Current status word, carry in bit 7 |
| status_out | output | 8 | Updated status word |
| status_we | output | 1 | Write strobe for `status_out` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench counts the clock edges at which `cyc_en` is high while the unit is busy. It expects `done`, `status_we` and the new status word in the clock right after the edge that carries the second such enable. It samples that value at the falling edge that follows, and it also checks that `done` is low at every earlier sample and at the next one. The read address and space select are checked at each falling edge before that second enable, because they are due one clock after `start` is taken. An ignored `start` is judged by `busy` one clock later and by the absence of `done` over the following clocks.

// File: rtl/carry_and_unit.sv
module carry_and_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cyc_en,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic [7:0]  bit_addr,
  output logic [7:0]  rd_addr,
  output logic        rd_sfr,
  input  logic [7:0]  ram_rdata,
  input  logic [7:0]  sfr_rdata,
  input  logic [31:0] port_latch,
  input  logic [7:0]  status_in,
  output logic [7:0]  status_out,
  output logic        status_we,
  output logic        busy,
  output logic        done
);
  localparam logic [7:0] OP_AND  = 8'h82;
  localparam logic [7:0] OP_ANDN = 8'hB0;

  logic       busy_q, phase_q, inv_q, bit_q, done_q;
  logic [7:0] addr_q, stat_q, byte_sel;
  logic       legal, is_port, src_bit;

  assign legal   = (opcode == OP_AND) || (opcode == OP_ANDN);
  assign rd_sfr  = addr_q[7];
  assign rd_addr = addr_q[7] ? {addr_q[7:3], 3'b000} : {4'h2, addr_q[6:3]};
  assign is_port = (addr_q[7:6] == 2'b10) && !addr_q[3];

  always_comb begin
    if (!rd_sfr)      byte_sel = ram_rdata;
    else if (is_port) byte_sel = port_latch[{addr_q[5:4], 3'b000} +: 8];
    else              byte_sel = sfr_rdata;
  end

  assign src_bit = byte_sel[addr_q[2:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      inv_q   <= 1'b0;
      bit_q   <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= 8'h00;
      stat_q  <= 8'h00;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start && legal) begin
          busy_q  <= 1'b1;
          phase_q <= 1'b0;
          inv_q   <= (opcode == OP_ANDN);
          addr_q  <= bit_addr;
        end
      end else if (cyc_en) begin
        if (!phase_q) begin
          phase_q <= 1'b1;
          bit_q   <= src_bit;
        end else begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          stat_q <= {status_in[7] & (bit_q ^ inv_q), status_in[6:0]};
        end
      end
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign status_we  = done_q;
  assign status_out = stat_q;
endmodule

// File: rtl/carry_and_unit_chk.sv
module carry_and_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [7:0] opcode,
  input logic [7:0] rd_addr,
  input logic       rd_sfr,
  input logic [7:0] status_in,
  input logic [7:0] status_out,
  input logic       status_we,
  input logic       busy,
  input logic       done
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && status_we)); // R7
  AST_CARRY_NOT_SET: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!status_out[7] || $past(status_in[7]))); // R8
  AST_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n) done |-> (status_out[6:0] == $past(status_in[6:0]))); // R8
  AST_RAM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) (busy && !rd_sfr) |-> (rd_addr[7:4] == 4'h2)); // R4
  AST_SFR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n) (busy && rd_sfr) |-> (rd_addr[7] && rd_addr[2:0] == 3'b000)); // R5
  AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (!rst_n) (!busy && start && opcode != 8'h82 && opcode != 8'hB0) |=> !busy); // R9
endmodule

bind carry_and_unit carry_and_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
  .rd_addr(rd_addr), .rd_sfr(rd_sfr), .status_in(status_in),
  .status_out(status_out), .status_we(status_we), .busy(busy), .done(done)
);

// File: tb/carry_and_unit_tb.sv
`timescale 1ns/1ps
module carry_and_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_en = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [7:0]  bit_addr = 8'h00;
  logic [7:0]  rd_addr;
  logic        rd_sfr;
  logic [7:0]  ram_rdata, sfr_rdata;
  logic [31:0] port_latch = 32'h0;
  logic [7:0]  status_in = 8'h00;
  logic [7:0]  status_out;
  logic        status_we, busy, done;

  logic [7:0] ram [0:255];
  logic [7:0] sfr [0:255];
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  assign ram_rdata = ram[rd_addr];
  assign sfr_rdata = sfr[rd_addr];

  carry_and_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .start(start), .opcode(opcode),
    .bit_addr(bit_addr), .rd_addr(rd_addr), .rd_sfr(rd_sfr), .ram_rdata(ram_rdata),
    .sfr_rdata(sfr_rdata), .port_latch(port_latch), .status_in(status_in),
    .status_out(status_out), .status_we(status_we), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte_addr(input logic [7:0] a);
    return a[7] ? (a & 8'hF8) : (8'h20 + (a >> 3));
  endfunction

  function automatic logic exp_bit(input logic [7:0] a);
    logic [7:0] b;
    b = exp_byte_addr(a);
    if (!a[7]) return ram[b][a[2:0]];
    if (b == 8'h80 || b == 8'h90 || b == 8'hA0 || b == 8'hB0)
      return port_latch[32'(b[5:4]) * 8 + 32'(a[2:0])];
    return sfr[b][a[2:0]];
  endfunction

  task automatic run_op(input logic [7:0] op, input logic [7:0] a, input logic c, input bit poke);
    logic [7:0] st, expst;
    logic eb;
    int n;
    st = 8'($urandom);
    st[7] = c;
    eb = exp_bit(a);
    expst = {c & (op == 8'hB0 ? ~eb : eb), st[6:0]};
    @(negedge clk);
    start = 1'b1; opcode = op; bit_addr = a; status_in = st; cyc_en = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (n < 2) begin
      check(busy === 1'b1 && done === 1'b0, "R7", {busy, done}, 2'b10);
      check(rd_addr === exp_byte_addr(a) && rd_sfr === a[7], a[7] ? "R5" : "R4", rd_addr, exp_byte_addr(a));
      cyc_en = 1'($urandom);
      if (poke && n == 1) begin
        start = 1'b1; opcode = 8'h82 ^ op ^ 8'hB0; bit_addr = ~a;
      end
      @(posedge clk);
      if (cyc_en) n++;
      @(negedge clk);
      start = 1'b0;
      if (poke) check(rd_addr === exp_byte_addr(a), "R10", rd_addr, exp_byte_addr(a));
    end
    check(done === 1'b1 && status_we === 1'b1 && busy === 1'b0, "R7", {done, status_we, busy}, 3'b110);
    check(status_out === expst, op == 8'hB0 ? "R3" : "R2", status_out, expst);
    if (!c) check(status_out[7] === 1'b0, "R8", status_out[7], 0);
    if (a[7] && a[6] == 1'b0 && a[3] == 1'b0)
      check(status_out === expst, "R6", status_out, expst);
    cyc_en = 1'b0;
    @(negedge clk);
    check(done === 1'b0 && status_we === 1'b0, "R7", done, 0);
  endtask

  task automatic bad_op(input logic [7:0] op);
    @(negedge clk);
    start = 1'b1; opcode = op; bit_addr = 8'h05; cyc_en = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b0, "R9", busy, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(done === 1'b0 && busy === 1'b0, "R9", {busy, done}, 0);
    end
    cyc_en = 1'b0;
  endtask

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < 256; i++) begin
      ram[i] = 8'($urandom);
      sfr[i] = 8'($urandom);
    end
    port_latch = $urandom;
    sfr[8'h80] = ~port_latch[7:0];
    sfr[8'h90] = ~port_latch[15:8];
    sfr[8'hA0] = ~port_latch[23:16];
    sfr[8'hB0] = ~port_latch[31:24];
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && status_we === 1'b0, "R1", {busy, done, status_we}, 0);
    rst_n = 1'b1;

    ram[8'h20] = 8'h01; run_op(8'h82, 8'h00, 1'b1, 1'b0);
    ram[8'h2F] = 8'h7F; run_op(8'h82, 8'h7F, 1'b1, 1'b0);
    run_op(8'hB0, 8'h7F, 1'b1, 1'b0);
    ram[8'h21] = 8'hFF; run_op(8'h82, 8'h0A, 1'b0, 1'b0);
    run_op(8'hB0, 8'h0A, 1'b1, 1'b0);
    run_op(8'h82, 8'h80, 1'b1, 1'b0);
    run_op(8'hB0, 8'h97, 1'b1, 1'b0);
    run_op(8'h82, 8'hA5, 1'b1, 1'b0);
    run_op(8'h82, 8'hB3, 1'b1, 1'b1);
    run_op(8'hB0, 8'hD0, 1'b1, 1'b0);
    run_op(8'h82, 8'hFF, 1'b1, 1'b1);
    bad_op(8'h72);
    bad_op(8'hA0);
    for (int k = 0; k < 300; k++) begin
      logic [7:0] a;
      a = 8'($urandom);
      run_op($urandom % 2 ? 8'h82 : 8'hB0, a, 1'($urandom), 1'($urandom % 4 == 0));
      if (k % 50 == 0) port_latch = $urandom;
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule